// File: doc/BRIEF.md
# Serial CRC-5 Frame Engine

This block produces and checks a 5-bit cyclic redundancy code that protects the upper 19 bits of a 24-bit serial frame. A sender uses the result as the check field it places in the frame's lowest five bits. A receiver uses the match flag to accept or reject a frame. The block does not interpret the payload.

A frame reaches the engine in one of two ways. It can be loaded whole with a one-cycle start strobe, or it can be shifted in one bit per clock, most significant bit first. Before dividing, the engine puts a fixed seed word in place of the frame's low five bits. It then performs one division step per clock in a 6-bit step register. Every frame therefore takes the same number of cycles. When the last step completes, a one-cycle done pulse marks fresh checksum and match outputs. These outputs hold their values until the next computation finishes.

Top module: `crc5_frame_engine`

## Requirements
- R1: `crc_o` equals the remainder of the modulo-2 division of the 24-bit value {frame[23:5], 5'b00111} by the generator 110101 (x^5+x^4+x^2+1). With an all-zero payload this remainder is 5'b00111.
- R2: The low five bits of a frame have no effect on `crc_o`.
- R3: `match_o` is 1 exactly when the computed checksum equals the frame's received bits [4:0].
- R4: After a start is accepted, `busy_o` is high for exactly 19 cycles. `done_o` is high for a single cycle, in the first cycle in which `busy_o` is low again.
- R5: `crc_o` and `match_o` change only in a cycle where `done_o` is high. At all other times they keep their value.
- R6: A `start_i` pulse that arrives while `busy_o` is high is ignored. It does not change the running result and does not produce an extra `done_o`.
- R7: Serial feed: each cycle with `ser_valid_i` high takes `ser_bit_i` as the next frame bit, starting with bit 23. The clock edge that takes the 24th bit starts a computation, exactly as a `start_i` at that edge would.
- R8: Serial bits presented while `busy_o` is high are ignored and do not count toward a frame.
- R9: If `start_i` and `ser_valid_i` are both high while the engine is idle, the parallel frame wins. Any partly gathered serial frame is discarded.
- R10: While reset is held and after it is released, `busy_o`, `done_o`, `crc_o` and `match_o` read 0 until the first computation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Load `frame_i` and begin a computation (ignored while busy) |
| frame_i | input | 24 | Parallel frame, payload in [23:5], check field in [4:0] |
| ser_valid_i | input | 1 | Serial bit strobe |
| ser_bit_i | input | 1 | Serial frame bit, most significant first |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle pulse when a new result is presented |
| crc_o | output | 5 | Computed checksum |
| match_o | output | 1 | Computed checksum equals received check field |

## Verification
The hardest situations to reach are those where an ignored input would otherwise leave lasting effects. One is a start or a burst of serial bits arriving in the middle of a division. The other is a parallel start that cuts across a half-gathered serial frame. For each case the bench first drives such a burst. It then sends a complete serial frame and expects exactly the checksum of that frame. A stray bit counted in the bit counter would shift the frame boundary and show up as a wrong checksum, an early done, or a done the scoreboard does not expect.

// File: rtl/crc5_pkg.sv
package crc5_pkg;

  localparam int          FRAME_W_DEF = 24;
  localparam int          CRC_W_DEF   = 5;
  localparam logic [5:0]  POLY_DEF    = 6'b110101;
  localparam logic [4:0]  SEED_DEF    = 5'b00111;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

endpackage

// File: rtl/crc5_rst_sync.sv
module crc5_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/crc5_div_step.sv
module crc5_div_step #(
  parameter int                STEP_W = 6,
  parameter logic [STEP_W-1:0] POLY   = 6'b110101
) (
  input  logic [STEP_W-1:0] in_i,
  output logic [STEP_W-1:0] out_o
);

  // Subtract (XOR) the generator only when the leading bit is set.
  always_comb begin
    if (in_i[STEP_W-1]) out_o = in_i ^ POLY;
    else                out_o = in_i;
  end

endmodule

// File: rtl/crc5_ser_gather.sv
module crc5_ser_gather #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_valid_i,
  input  logic               ser_bit_i,
  input  logic               block_i,
  input  logic               flush_i,
  output logic               full_o,
  output logic [FRAME_W-1:0] frame_o
);

  localparam int              CW     = $clog2(FRAME_W);
  localparam logic [CW-1:0]   LAST_C = CW'(FRAME_W - 1);

  logic [CW-1:0]      cnt_q, cnt_d;
  logic [FRAME_W-2:0] acc_q, acc_d;
  logic               take;

  assign take    = ser_valid_i & ~block_i & ~flush_i;
  assign full_o  = take & (cnt_q == LAST_C);
  assign frame_o = {acc_q, ser_bit_i};

  always_comb begin
    cnt_d = cnt_q;
    acc_d = acc_q;
    if (flush_i || full_o) begin
      cnt_d = '0;
    end else if (take) begin
      cnt_d = cnt_q + 1'b1;
      acc_d = {acc_q[FRAME_W-3:0], ser_bit_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/crc5_ctl.sv
module crc5_ctl
  import crc5_pkg::*;
#(
  parameter int STEPS = 19
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  output logic busy_o,
  output logic first_o,
  output logic last_o,
  output logic done_o
);

  localparam int            CW     = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST_C = CW'(STEPS - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  assign busy_o  = (ph_q == PH_RUN);
  assign first_o = busy_o & (cnt_q == '0);
  assign last_o  = busy_o & (cnt_q == LAST_C);
  assign done_o  = done_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (busy_o) begin
      cnt_d = cnt_q + 1'b1;
      if (last_o) begin
        ph_d   = PH_IDLE;
        done_d = 1'b1;
      end
    end else if (launch_i) begin
      ph_d  = PH_RUN;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/crc5_frame_engine.sv
module crc5_frame_engine
  import crc5_pkg::*;
#(
  parameter int               FRAME_W = FRAME_W_DEF,
  parameter int               CRC_W   = CRC_W_DEF,
  parameter logic [CRC_W:0]   POLY    = POLY_DEF,
  parameter logic [CRC_W-1:0] SEED    = SEED_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               ser_valid_i,
  input  logic               ser_bit_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [CRC_W-1:0]   crc_o,
  output logic               match_o
);

  localparam int STEP_W = CRC_W + 1;
  localparam int TAIL_W = FRAME_W - STEP_W;
  localparam int STEPS  = FRAME_W - CRC_W;

  logic               rst_i_n;
  logic               busy, first, last, start_acc, ser_full, launch;
  logic [FRAME_W-1:0] ser_frame, sel_frame, seeded;
  logic [STEP_W-1:0]  step_q, step_d, div_in, div_out;
  logic [TAIL_W-1:0]  tail_q, tail_d;
  logic [CRC_W-1:0]   rx_q, rx_d, crc_q, crc_d;
  logic               match_q, match_d;

  crc5_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign start_acc = start_i & ~busy;
  assign launch    = start_acc | ser_full;
  assign sel_frame = start_acc ? frame_i : ser_frame;
  assign seeded    = {sel_frame[FRAME_W-1:CRC_W], SEED};

  crc5_ser_gather #(.FRAME_W(FRAME_W)) u_gather (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .ser_valid_i (ser_valid_i),
    .ser_bit_i   (ser_bit_i),
    .block_i     (busy),
    .flush_i     (start_acc),
    .full_o      (ser_full),
    .frame_o     (ser_frame)
  );

  crc5_ctl #(.STEPS(STEPS)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .launch_i (launch),
    .busy_o   (busy),
    .first_o  (first),
    .last_o   (last),
    .done_o   (done_o)
  );

  // The first step reduces the raw top bits; later steps shift in one tail bit.
  assign div_in = first ? step_q : {step_q[CRC_W-1:0], tail_q[TAIL_W-1]};

  crc5_div_step #(.STEP_W(STEP_W), .POLY(POLY)) u_step (
    .in_i  (div_in),
    .out_o (div_out)
  );

  always_comb begin
    step_d  = step_q;
    tail_d  = tail_q;
    rx_d    = rx_q;
    crc_d   = crc_q;
    match_d = match_q;
    if (busy) begin
      step_d = div_out;
      if (!first) tail_d = {tail_q[TAIL_W-2:0], 1'b0};
      if (last) begin
        crc_d   = div_out[CRC_W-1:0];
        match_d = (div_out[CRC_W-1:0] == rx_q);
      end
    end else if (launch) begin
      step_d = seeded[FRAME_W-1:TAIL_W];
      tail_d = seeded[TAIL_W-1:0];
      rx_d   = sel_frame[CRC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      step_q  <= '0;
      tail_q  <= '0;
      rx_q    <= '0;
      crc_q   <= '0;
      match_q <= 1'b0;
    end else begin
      step_q  <= step_d;
      tail_q  <= tail_d;
      rx_q    <= rx_d;
      crc_q   <= crc_d;
      match_q <= match_d;
    end
  end

  assign busy_o  = busy;
  assign crc_o   = crc_q;
  assign match_o = match_q;

endmodule

// File: rtl/crc5_frame_engine_chk.sv
module crc5_frame_engine_chk #(
  parameter int CRC_W = 5,
  parameter int STEPS = 19
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic [CRC_W-1:0] crc_o,
  input logic             match_o
);

  localparam int            CW      = $clog2(STEPS + 2);
  localparam logic [CW-1:0] STEPS_C = CW'(STEPS);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_q == STEPS_C)); // R4

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_q < STEPS_C)); // R6

  AST_DONE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R4

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(crc_o) && $stable(match_o))); // R5

endmodule

bind crc5_frame_engine crc5_frame_engine_chk #(
  .CRC_W (CRC_W),
  .STEPS (FRAME_W - CRC_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .crc_o   (crc_o),
  .match_o (match_o)
);

// File: tb/crc5_frame_engine_tb.sv
module crc5_frame_engine_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] frame_i = '0;
  logic        ser_valid_i = 1'b0;
  logic        ser_bit_i = 1'b0;
  logic        busy_o, done_o, match_o;
  logic [4:0]  crc_o;

  typedef struct {
    logic [4:0] crc;
    logic       match;
    string      tag;
  } exp_t;

  exp_t       sbq[$];
  exp_t       cur;
  int         checks = 0;
  int         errors = 0;
  int         busy_run = 0;
  bit         have_last = 1'b0;
  bit         finished = 1'b0;
  logic [4:0] last_crc = '0;
  logic       last_match = 1'b0;

  crc5_frame_engine u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .frame_i     (frame_i),
    .ser_valid_i (ser_valid_i),
    .ser_bit_i   (ser_bit_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .crc_o       (crc_o),
    .match_o     (match_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Classical long division of the seeded 24-bit word (R1, R2).
  function automatic logic [4:0] ref_crc(input logic [23:0] f);
    logic [23:0] v;
    v = {f[23:5], 5'b00111};
    for (int i = 23; i >= 5; i--)
      if (v[i]) v = v ^ (24'(6'b110101) << (i - 5));
    return v[4:0];
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_exp(input logic [23:0] f, input string tag);
    exp_t e;
    e.crc   = ref_crc(f);
    e.match = (ref_crc(f) == f[4:0]);
    e.tag   = tag;
    sbq.push_back(e);
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic drain();
    while (sbq.size() != 0 || busy_o) @(negedge clk);
  endtask

  task automatic send_par(input logic [23:0] f, input string tag);
    wait_idle();
    push_exp(f, tag);
    start_i = 1'b1;
    frame_i = f;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic send_ser(input logic [23:0] f, input string tag);
    wait_idle();
    push_exp(f, tag);
    for (int i = 23; i >= 0; i--) begin
      ser_valid_i = 1'b1;
      ser_bit_i   = f[i];
      @(negedge clk);
    end
    ser_valid_i = 1'b0;
  endtask

  // Monitor: scoreboard pop on done, hold check and busy span check.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        if (sbq.size() == 0) begin
          check(1'b0, "R6", "done without pending frame", 1, 0);
        end else begin
          cur = sbq.pop_front();
          check(crc_o == cur.crc, cur.tag, "crc", int'(crc_o), int'(cur.crc));
          check(match_o == cur.match, "R3", "match", int'(match_o), int'(cur.match));
        end
        last_crc   = crc_o;
        last_match = match_o;
        have_last  = 1'b1;
      end else if (have_last) begin
        check(crc_o == last_crc && match_o == last_match, "R5", "result hold",
              int'({match_o, crc_o}), int'({last_match, last_crc}));
      end
      if (busy_o) begin
        busy_run++;
      end else if (busy_run != 0) begin
        check(busy_run == 19, "R4", "busy length", busy_run, 19);
        check(done_o == 1'b1, "R4", "done after busy", int'(done_o), 1);
        busy_run = 0;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] f;
    logic [18:0] p;

    repeat (3) @(negedge clk);
    check(busy_o == 1'b0 && done_o == 1'b0, "R10", "idle in reset",
          int'({busy_o, done_o}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy_o == 1'b0, "R10", "busy after reset", int'(busy_o), 0);
    check(done_o == 1'b0, "R10", "done after reset", int'(done_o), 0);
    check(crc_o == 5'd0, "R10", "crc after reset", int'(crc_o), 0);
    check(match_o == 1'b0, "R10", "match after reset", int'(match_o), 0);

    // R1: zero payload gives the seed itself.
    send_par(24'h000000, "R1");
    drain();
    check(last_crc == 5'b00111, "R1", "zero payload crc", int'(last_crc), 7);
    send_par(24'hFFFFFF, "R1");
    send_par(24'h800000, "R1");
    for (int k = 0; k < 8; k++) send_par(24'($urandom), "R1");

    // R2: same payload, differing check fields.
    p = 19'h2C3A5;
    send_par({p, 5'h00}, "R2");
    drain();
    f[4:0] = last_crc;
    send_par({p, 5'h1F}, "R2");
    send_par({p, 5'h0A}, "R2");
    drain();
    check(last_crc == f[4:0], "R2", "crc independent of low bits",
          int'(last_crc), int'(f[4:0]));

    // R3: correct and corrupted frames.
    p = 19'h5A3C1;
    f = {p, ref_crc({p, 5'b0})};
    send_par(f, "R3");
    send_par(f ^ 24'h000100, "R3");
    send_par(f ^ 24'h000001, "R3");
    drain();
    check(last_match == 1'b0, "R3", "corrupted check field", int'(last_match), 0);

    // R7: serial frames.
    send_ser(f, "R7");
    send_ser(24'hA5C3E1, "R7");
    send_ser(24'h13579B, "R7");

    // R6 and R8: start pulse and serial bits during a division.
    send_par(24'h6D2B11, "R6");
    start_i = 1'b1;
    frame_i = 24'h0F0F0F;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 10; k++) begin
      ser_valid_i = 1'b1;
      ser_bit_i   = k[0];
      @(negedge clk);
    end
    ser_valid_i = 1'b0;
    drain();
    send_ser(24'h3C9E47, "R8");

    // R9: parallel start cuts a partial serial frame.
    drain();
    for (int k = 0; k < 12; k++) begin
      ser_valid_i = 1'b1;
      ser_bit_i   = ~k[0];
      @(negedge clk);
    end
    push_exp(24'hBEEF12, "R9");
    start_i     = 1'b1;
    frame_i     = 24'hBEEF12;
    ser_valid_i = 1'b1;
    ser_bit_i   = 1'b1;
    @(negedge clk);
    start_i     = 1'b0;
    ser_valid_i = 1'b0;
    send_ser(24'h71A0C6, "R9");

    drain();
    repeat (30) @(negedge clk);
    check(sbq.size() == 0, "R6", "no pending results", sbq.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule